// File: doc/BRIEF.md
# Pad Pull and Drive-Strength Configuration Unit

This unit holds the pull-resistor and drive-strength settings for a bank of pads (32 by default) and presents them to the pad ring as one pull-up enable, one pull-down enable and one 3-bit drive code per pin. Software reaches the settings through a simple 32-bit register bus with a one-cycle read latency. Two per-pin command ports are also provided. A pull command applies off, up or down to one pin. A strength command takes a milliamp value, checks it, converts it to a drive code and stores that code for one pin.

The pull storage has two layouts, chosen at build time. In the first, an enable register turns a pin's resistor on and a select register picks its direction. In the second, independent pull-up and pull-down registers are used. The drive code is stored bit-sliced: each code bit has its own 32-bit register with one bit per pin. A build-time switch reverses the order of the three bit registers in the address space. A read-only status word shows which pins have no pull active. A query port converts any pin's stored code back to milliamps.

Top module: `pad_cfg_unit`

## Requirements
- R1: After reset all pull outputs and drive codes are zero. A strength query reports 2 mA. Every pull and drive register reads back as 0, and the pull status word reads all ones.
- R2: `pad_pu` and `pad_pd` are never both high for the same pin. In the split layout, a pin with both its up and down bits set drives pull-up only. Pad outputs follow register changes one clock later.
- R3: With PULL_SPLIT=0, the select register sits at 0x34 (1 = up, 0 = down) and the enable register at 0x38. A pin pulls up when enable and select are both 1. It pulls down when enable is 1 and select is 0.
- R4: With PULL_SPLIT=1, the pull-down register sits at 0x10 and the pull-up register at 0x14. Each bit drives its pin directly, subject to R2.
- R5: Pull command modes are 2'b00 off, 2'b01 up, 2'b10 down and 2'b11 ignored, and each acts on bit `pull_cmd_pin` only. In the split layout, off clears both bits, and up or down sets that bit and clears the other. In the enable/select layout, off clears only the enable bit and leaves select unchanged. Up or down sets the enable bit and writes select.
- R6: Code bit k of pin p is bit p of the register at DRV_BASE+4k. With DRV_REVERSE=1 the order flips: bit 2 is at DRV_BASE and bit 0 is at DRV_BASE+8.
- R7: A strength command of 2 to 16 mA in even steps stores code mA/2-1 for that pin and leaves all other pins unchanged.
- R8: A strength command that is odd, below 2 or above 16 raises `str_cmd_reject` for one cycle after it is issued and changes no register.
- R9: `str_q_ma` gives (code+1)*2 for pin `str_q_pin`, one cycle after the code or pin changes.
- R10: Status register 0x3C reads bit p set when pin p has neither pull active. Writes to it have no effect.
- R11: Addresses that are not mapped read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| pull_cmd_valid | input | 1 | Pull command strobe |
| pull_cmd_pin | input | 5 | Pin addressed by the pull command |
| pull_cmd_mode | input | 2 | 0 off, 1 up, 2 down, 3 ignored |
| str_cmd_valid | input | 1 | Strength command strobe |
| str_cmd_pin | input | 5 | Pin addressed by the strength command |
| str_cmd_ma | input | 5 | Requested strength in mA |
| str_cmd_reject | output | 1 | One-cycle pulse for an illegal request |
| str_q_pin | input | 5 | Pin whose strength is queried |
| str_q_ma | output | 5 | Queried strength in mA |
| pad_pu | output | 32 | Per-pin pull-up enable |
| pad_pd | output | 32 | Per-pin pull-down enable |
| pad_drv | output | 96 | Per-pin 3-bit drive code, pin p at bits 3p+2..3p |

## Verification
Assertions check on every cycle that the two pull outputs never overlap, that the queried strength is always an even value from 2 to 16, and that each command lands on its pin: off clears the pull, up sets it, an illegal strength leaves the drive bits untouched and a legal one stores the right code. The bench's scenarios are needed to show the address map of both pull layouts and both bit-register orders, the effect of mixed bus writes on several pins at once, the status word, and that unmapped or read-only addresses ignore writes. Two instances with opposite parameter choices share one stimulus stream, so each layout also sees the other layout's addresses as unmapped.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
  localparam int DRV_BITS = 3;
  localparam int MA_W     = 5;

  typedef logic [DRV_BITS-1:0] drv_code_t;
  typedef logic [MA_W-1:0]     ma_t;

  typedef enum logic [1:0] {
    PM_OFF  = 2'd0,
    PM_UP   = 2'd1,
    PM_DOWN = 2'd2,
    PM_RSVD = 2'd3
  } pull_mode_e;

  // even value from 2 to 16
  function automatic logic ma_ok(input ma_t ma);
    return (ma[0] == 1'b0) && (ma >= 5'd2) && (ma <= 5'd16);
  endfunction

  function automatic drv_code_t ma_to_code(input ma_t ma);
    ma_t half;
    half = (ma >> 1) - 5'd1;
    return half[DRV_BITS-1:0];
  endfunction

  function automatic ma_t code_to_ma(input drv_code_t c);
    return {1'b0, c, 1'b0} + 5'd2;
  endfunction
endpackage

// File: rtl/pad_pull_bank.sv
module pad_pull_bank
  import pad_cfg_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int PIN_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SPLIT  = 0,
  parameter int A_ADDR = 'h34,
  parameter int B_ADDR = 'h38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_valid,
  input  logic [PIN_W-1:0]  cmd_pin,
  input  pull_mode_e        cmd_mode,
  output logic [NPINS-1:0]  ra,
  output logic [NPINS-1:0]  rb,
  output logic [NPINS-1:0]  pu_c,
  output logic [NPINS-1:0]  pd_c
);
  // ra: select (enable/select layout) or pull-up (split layout)
  // rb: enable (enable/select layout) or pull-down (split layout)
  logic [NPINS-1:0] ra_n, rb_n;

  always_comb begin
    ra_n = ra;
    rb_n = rb;
    if (we && addr == ADDR_W'(A_ADDR)) ra_n = wdata[NPINS-1:0];
    if (we && addr == ADDR_W'(B_ADDR)) rb_n = wdata[NPINS-1:0];
    if (cmd_valid && int'(cmd_pin) < NPINS) begin
      case (cmd_mode)
        PM_OFF: begin
          rb_n[cmd_pin] = 1'b0;
          if (SPLIT != 0) ra_n[cmd_pin] = 1'b0;
        end
        PM_UP: begin
          ra_n[cmd_pin] = 1'b1;
          rb_n[cmd_pin] = (SPLIT == 0);
        end
        PM_DOWN: begin
          ra_n[cmd_pin] = 1'b0;
          rb_n[cmd_pin] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra <= '0;
      rb <= '0;
    end else begin
      ra <= ra_n;
      rb <= rb_n;
    end
  end

  generate
    if (SPLIT != 0) begin : g_split
      assign pu_c = ra;
      assign pd_c = rb & ~ra;   // pull-up wins
    end else begin : g_ensel
      assign pu_c = rb & ra;
      assign pd_c = rb & ~ra;
    end
  endgenerate

  p_off_clears_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_mode == PM_OFF |=> !rb[$past(cmd_pin)]);

  p_up_sets_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_mode == PM_UP |=> ra[$past(cmd_pin)]);

  p_rsvd_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_mode == PM_RSVD && !we |=> $stable(ra) && $stable(rb));

  generate
    if (SPLIT != 0) begin : g_split_chk
      p_split_down_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_mode == PM_DOWN |=> !ra[$past(cmd_pin)] && rb[$past(cmd_pin)]);
    end
  endgenerate
endmodule

// File: rtl/pad_drive_bank.sv
module pad_drive_bank
  import pad_cfg_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int PIN_W   = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BASE    = 'h00,
  parameter int REVERSE = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          str_valid,
  input  logic [PIN_W-1:0]              str_pin,
  input  ma_t                           str_ma,
  output logic [DRV_BITS-1:0][NPINS-1:0] slot_q,
  output logic [NPINS*DRV_BITS-1:0]     code_flat
);
  logic [DRV_BITS-1:0][NPINS-1:0] bit_q;
  logic      str_take;
  drv_code_t str_code;

  assign str_take = str_valid && ma_ok(str_ma) && (int'(str_pin) < NPINS);
  assign str_code = ma_to_code(str_ma);

  generate
    for (genvar k = 0; k < DRV_BITS; k++) begin : g_slot
      localparam int BI = (REVERSE != 0) ? (DRV_BITS - 1 - k) : k;
      localparam int SA = BASE + 4 * k;
      logic [NPINS-1:0] q, q_n;

      always_comb begin
        q_n = q;
        if (we && addr == ADDR_W'(SA)) q_n = wdata[NPINS-1:0];
        if (str_take) q_n[str_pin] = str_code[BI];
      end

      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_n;
      end

      assign slot_q[k] = q;
      assign bit_q[BI] = q;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      for (genvar b = 0; b < DRV_BITS; b++) begin : g_bit
        assign code_flat[p*DRV_BITS + b] = bit_q[b][p];
      end
    end
  endgenerate

  function automatic drv_code_t code_of(input logic [PIN_W-1:0] p);
    drv_code_t c;
    for (int b = 0; b < DRV_BITS; b++) c[b] = bit_q[b][p];
    return c;
  endfunction

  p_reject_holds_r8: assert property (@(posedge clk) disable iff (rst)
    str_valid && !ma_ok(str_ma) && !we |=> $stable(bit_q));

  p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
    str_valid && ma_ok(str_ma) |=> code_of($past(str_pin)) == ma_to_code($past(str_ma)));
endmodule

// File: rtl/pad_cfg_unit.sv
module pad_cfg_unit
  import pad_cfg_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PULL_SPLIT  = 0,
  parameter int DRV_REVERSE = 0,
  parameter int DRV_BASE    = 'h00,
  parameter int SEL_ADDR    = 'h34,
  parameter int EN_ADDR     = 'h38,
  parameter int DN_ADDR     = 'h10,
  parameter int UP_ADDR     = 'h14,
  parameter int PSTAT_ADDR  = 'h3C,
  localparam int PIN_W      = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic                      bus_re,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      pull_cmd_valid,
  input  logic [PIN_W-1:0]          pull_cmd_pin,
  input  logic [1:0]                pull_cmd_mode,
  input  logic                      str_cmd_valid,
  input  logic [PIN_W-1:0]          str_cmd_pin,
  input  logic [MA_W-1:0]           str_cmd_ma,
  output logic                      str_cmd_reject,
  input  logic [PIN_W-1:0]          str_q_pin,
  output logic [MA_W-1:0]           str_q_ma,
  output logic [NPINS-1:0]          pad_pu,
  output logic [NPINS-1:0]          pad_pd,
  output logic [NPINS*DRV_BITS-1:0] pad_drv
);
  localparam int REGA_ADDR = (PULL_SPLIT != 0) ? UP_ADDR : SEL_ADDR;
  localparam int REGB_ADDR = (PULL_SPLIT != 0) ? DN_ADDR : EN_ADDR;

  logic [NPINS-1:0] ra, rb, pu_c, pd_c;
  logic [DRV_BITS-1:0][NPINS-1:0] slot_q;
  logic [NPINS*DRV_BITS-1:0] code_flat;
  logic [DATA_W-1:0] rd_n;
  drv_code_t q_code;

  pad_pull_bank #(
    .NPINS(NPINS), .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SPLIT(PULL_SPLIT), .A_ADDR(REGA_ADDR), .B_ADDR(REGB_ADDR)
  ) u_pull (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cmd_valid(pull_cmd_valid), .cmd_pin(pull_cmd_pin),
    .cmd_mode(pull_mode_e'(pull_cmd_mode)),
    .ra(ra), .rb(rb), .pu_c(pu_c), .pd_c(pd_c)
  );

  pad_drive_bank #(
    .NPINS(NPINS), .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BASE(DRV_BASE), .REVERSE(DRV_REVERSE)
  ) u_drive (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .str_valid(str_cmd_valid), .str_pin(str_cmd_pin), .str_ma(str_cmd_ma),
    .slot_q(slot_q), .code_flat(code_flat)
  );

  always_comb begin
    rd_n = '0;
    if (bus_addr == ADDR_W'(REGA_ADDR))  rd_n = DATA_W'(ra);
    if (bus_addr == ADDR_W'(REGB_ADDR))  rd_n = DATA_W'(rb);
    if (bus_addr == ADDR_W'(PSTAT_ADDR)) rd_n = DATA_W'(~(pu_c | pd_c));
    for (int k = 0; k < DRV_BITS; k++)
      if (bus_addr == ADDR_W'(DRV_BASE + 4 * k)) rd_n = DATA_W'(slot_q[k]);
  end

  assign q_code = code_flat[int'(str_q_pin)*DRV_BITS +: DRV_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata      <= '0;
      str_cmd_reject <= 1'b0;
      str_q_ma       <= code_to_ma('0);
      pad_pu         <= '0;
      pad_pd         <= '0;
      pad_drv        <= '0;
    end else begin
      if (bus_re) bus_rdata <= rd_n;
      str_cmd_reject <= str_cmd_valid && !ma_ok(str_cmd_ma);
      str_q_ma       <= code_to_ma(q_code);
      pad_pu         <= pu_c;
      pad_pd         <= pd_c;
      pad_drv        <= code_flat;
    end
  end

  p_pull_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  p_query_legal_r9: assert property (@(posedge clk) disable iff (rst)
    str_q_ma[0] == 1'b0 && str_q_ma >= 5'd2 && str_q_ma <= 5'd16);

  p_reject_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    str_cmd_valid && !ma_ok(str_cmd_ma) |=> str_cmd_reject);

  p_no_reject_legal_r7: assert property (@(posedge clk) disable iff (rst)
    str_cmd_valid && ma_ok(str_cmd_ma) |=> !str_cmd_reject);
endmodule

// File: tb/test_pad_cfg_unit.sv
module test_pad_cfg_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic        bus_we = 0, bus_re = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        pull_cmd_valid = 0;
  logic [4:0]  pull_cmd_pin = 0;
  logic [1:0]  pull_cmd_mode = 0;
  logic        str_cmd_valid = 0;
  logic [4:0]  str_cmd_pin = 0;
  logic [4:0]  str_cmd_ma = 0;
  logic [4:0]  str_q_pin = 0;

  logic [31:0] rd_a, rd_b, pu_a, pu_b, pd_a, pd_b;
  logic [95:0] drv_a, drv_b;
  logic        rej_a, rej_b;
  logic [4:0]  qma_a, qma_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // enable/select layout, normal bit order
  pad_cfg_unit #(.PULL_SPLIT(0), .DRV_REVERSE(0)) i_pad_cfg_unit (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pull_cmd_valid(pull_cmd_valid),
    .pull_cmd_pin(pull_cmd_pin), .pull_cmd_mode(pull_cmd_mode),
    .str_cmd_valid(str_cmd_valid), .str_cmd_pin(str_cmd_pin), .str_cmd_ma(str_cmd_ma),
    .str_cmd_reject(rej_a), .str_q_pin(str_q_pin), .str_q_ma(qma_a),
    .pad_pu(pu_a), .pad_pd(pd_a), .pad_drv(drv_a));

  // split layout, reversed bit order
  pad_cfg_unit #(.PULL_SPLIT(1), .DRV_REVERSE(1)) i_pad_cfg_unit_alt (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pull_cmd_valid(pull_cmd_valid),
    .pull_cmd_pin(pull_cmd_pin), .pull_cmd_mode(pull_cmd_mode),
    .str_cmd_valid(str_cmd_valid), .str_cmd_pin(str_cmd_pin), .str_cmd_ma(str_cmd_ma),
    .str_cmd_reject(rej_b), .str_q_pin(str_q_pin), .str_q_ma(qma_b),
    .pad_pu(pu_b), .pad_pd(pd_b), .pad_drv(drv_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] va, output logic [31:0] vb);
    @(negedge clk); bus_re = 1; bus_addr = a;
    @(negedge clk); bus_re = 0; va = rd_a; vb = rd_b;
  endtask

  task automatic pull_cmd(input logic [4:0] p, input logic [1:0] m);
    @(negedge clk); pull_cmd_valid = 1; pull_cmd_pin = p; pull_cmd_mode = m;
    @(negedge clk); pull_cmd_valid = 0;
  endtask

  task automatic str_cmd(input logic [4:0] p, input logic [4:0] ma);
    @(negedge clk); str_cmd_valid = 1; str_cmd_pin = p; str_cmd_ma = ma;
    @(negedge clk); str_cmd_valid = 0;
  endtask

  task automatic query(input logic [4:0] p, output logic [4:0] va, output logic [4:0] vb);
    @(negedge clk); str_q_pin = p;
    @(negedge clk); va = qma_a; vb = qma_b;
  endtask

  task automatic t_reset;
    logic [31:0] a, b;
    chk("R1 pu a", pu_a, 0);  chk("R1 pd b", pd_b, 0);
    chk("R1 drv a", drv_a[31:0], 0); chk("R1 drv b", drv_b[31:0], 0);
    chk("R1 qma a", 32'(qma_a), 2); chk("R1 qma b", 32'(qma_b), 2);
    bus_rd(8'h04, a, b); chk("R1 slot a", a, 0); chk("R1 slot b", b, 0);
    bus_rd(8'h3C, a, b); chk("R1/R10 stat a", a, 32'hFFFFFFFF); chk("R1/R10 stat b", b, 32'hFFFFFFFF);
  endtask

  task automatic t_ensel;
    logic [31:0] a, b;
    bus_wr(8'h34, 32'h0000_00F0);
    bus_wr(8'h38, 32'h0000_00CC);
    @(negedge clk);
    chk("R3 pu a", pu_a, 32'h0000_00C0); chk("R3 pd a", pd_a, 32'h0000_000C);
    chk("R11 pu b", pu_b, 0); chk("R11 pd b", pd_b, 0);
    bus_rd(8'h34, a, b); chk("R3 sel rb a", a, 32'h0000_00F0); chk("R11 rb b", b, 0);
    bus_rd(8'h3C, a, b); chk("R10 stat a", a, 32'hFFFF_FF33);
  endtask

  task automatic t_split;
    logic [31:0] a, b;
    bus_wr(8'h10, 32'h0000_0F00);
    bus_wr(8'h14, 32'h0000_3C00);
    @(negedge clk);
    chk("R4 pu b", pu_b, 32'h0000_3C00); chk("R2 pd b", pd_b, 32'h0000_0300);
    chk("R2 excl b", pu_b & pd_b, 0);
    chk("R11 pu a", pu_a, 32'h0000_00C0);
    bus_rd(8'h10, a, b); chk("R4 dn rb b", b, 32'h0000_0F00); chk("R11 rb a", a, 0);
  endtask

  task automatic t_pull_cmd;
    logic [31:0] a, b;
    pull_cmd(5'd20, 2'b01);
    pull_cmd(5'd10, 2'b00);
    pull_cmd(5'd6,  2'b10);
    pull_cmd(5'd7,  2'b00);
    @(negedge clk);
    chk("R5 pu a", pu_a, 32'h0010_0000); chk("R5 pd a", pd_a, 32'h0000_004C);
    chk("R5 pu b", pu_b, 32'h0010_3800); chk("R5 pd b", pd_b, 32'h0000_0340);
    pull_cmd(5'd3, 2'b11);
    @(negedge clk);
    chk("R5 rsvd pd a", pd_a, 32'h0000_004C); chk("R5 rsvd pu b", pu_b, 32'h0010_3800);
    bus_rd(8'h34, a, b); chk("R5 sel kept a", a, 32'h0010_00B0);
    bus_rd(8'h38, a, b); chk("R5 en a", a, 32'h0010_004C);
    bus_rd(8'h10, a, b); chk("R5 dn b", b, 32'h0000_0B40);
    bus_rd(8'h14, a, b); chk("R5 up b", b, 32'h0010_3800);
  endtask

  task automatic t_slices;
    logic [4:0] qa, qb;
    bus_wr(8'h00, 32'h1);
    bus_wr(8'h04, 32'h2);
    bus_wr(8'h08, 32'h4);
    @(negedge clk);
    chk("R6 a pin0", 32'(drv_a[2:0]), 1); chk("R6 a pin2", 32'(drv_a[8:6]), 4);
    chk("R6 b pin0", 32'(drv_b[2:0]), 4); chk("R6 b pin1", 32'(drv_b[5:3]), 2);
    chk("R6 b pin2", 32'(drv_b[8:6]), 1);
    query(5'd0, qa, qb);
    chk("R9 q a", 32'(qa), 4); chk("R9 q b", 32'(qb), 10);
  endtask

  task automatic t_strength;
    logic [31:0] a, b;
    logic [4:0] qa, qb;
    str_cmd(5'd5, 5'd14);
    chk("R7 no rej", 32'(rej_a), 0);
    query(5'd5, qa, qb); chk("R7/R9 q a", 32'(qa), 14); chk("R7/R9 q b", 32'(qb), 14);
    bus_rd(8'h08, a, b); chk("R7 slot2 a", a, 32'h24); chk("R7 slot2 b", b, 32'h04);
    bus_rd(8'h00, a, b); chk("R7 slot0 b", b, 32'h21);
    str_cmd(5'd31, 5'd16);
    query(5'd31, qa, qb); chk("R7 16mA", 32'(qa), 16);
    str_cmd(5'd0, 5'd2);
    @(negedge clk);
    chk("R7 pin0 a", 32'(drv_a[2:0]), 0); chk("R7 pin0 b", 32'(drv_b[2:0]), 0);
    chk("R7 pin1 kept", 32'(drv_b[5:3]), 2);
  endtask

  task automatic t_reject;
    logic [4:0] qa, qb;
    str_cmd(5'd5, 5'd15); chk("R8 odd a", 32'(rej_a), 1); chk("R8 odd b", 32'(rej_b), 1);
    str_cmd(5'd5, 5'd0);  chk("R8 zero", 32'(rej_a), 1);
    str_cmd(5'd5, 5'd18); chk("R8 high", 32'(rej_b), 1);
    @(negedge clk); chk("R8 pulse ends", 32'(rej_a), 0);
    query(5'd5, qa, qb); chk("R8 held a", 32'(qa), 14); chk("R8 held b", 32'(qb), 14);
  endtask

  task automatic t_status_unmapped;
    logic [31:0] a, b;
    bus_wr(8'h3C, 32'h0);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h3C, a, b); chk("R10 stat a", a, 32'hFFEF_FFB3); chk("R10 stat b", b, 32'hFFEF_C4BF);
    bus_rd(8'h20, a, b); chk("R11 unm a", a, 0); chk("R11 unm b", b, 0);
    chk("R11 pu kept", pu_b, 32'h0010_3800);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ensel();
    t_split();
    t_pull_cmd();
    t_slices();
    t_strength();
    t_reject();
    t_status_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule